// File: doc/BRIEF.md
# Stuck-At Test Pattern Search Engine

This block searches in hardware for an input pattern that exposes one chosen stuck-at fault in a small built-in gate network. The caller picks a net and a stuck level and pulses `start`. The engine then walks a binary decision tree over the five primary inputs. It assigns one input per step and evaluates the fault-free copy and the faulty copy of the network forward in three-valued logic. It also checks whether the assignment so far can still lead to a test.

The engine prunes a branch in two cases: the fault site already carries the stuck level in the fault-free copy, or no route of unknown nets is left from a differing net to the output. When a branch is pruned, the engine tries the other value at the newest unflipped decision. When the output itself differs between the two copies, the partial assignment is a test. When every decision has been flipped and the last branch still fails, no test exists.

The result stays on the outputs until the next `start`. Inputs the search never reached are reported as don't-care.

Top module: `podem_engine`

## Requirements
- R1: After reset, `done`, `found` and `untestable` are low and `test_vec` and `test_care` are all zero.
- R2: A `start` seen while idle or finished launches a new search that performs exactly one evaluation per clock. `done` rises on the clock edge of the evaluation that decides the result, so it rises N edges after the `start` edge when that result takes N evaluations.
- R3: Inputs are decided in the fixed order x0, x1, x2, x3, x4 (bit i of `test_vec` and `test_care` is xi). Value 0 is tried before 1. `test_care` is always a contiguous run of low bits, and a bit outside it reads 0 in `test_vec`.
- R4: An assignment is pruned when the fault-free value at the fault site equals `stuck_val`.
- R5: An assignment is pruned when no net that differs between the two copies (nor the still-unknown fault site) reaches the output through nets that are unknown in at least one copy.
- R6: A pruned branch flips the newest unflipped decision to 1, discards all later decisions, and continues the search from there.
- R7: `found` is raised when the output differs between the two copies. Every filling of the don't-care inputs then gives different fault-free and faulty outputs.
- R8: If no unflipped decision remains when a branch is pruned, `untestable` is raised and the vector and care mask read zero. A stuck-at-1 fault on net 6 is redundant and is reported this way.
- R9: A `site` value of 10 or more names no net and is reported untestable after a single evaluation.
- R10: `start` has no effect while a search runs. The verdict and vector hold steady while `done` is high, until the next `start`.
- R11: Nets are numbered 0 to 4 for x0 to x4, and the gates are defined as follows: n5 = NAND(x0,x1), n6 = OR(x2,x3), n7 = AND(n6,x2), n8 = AND(n7,x4), and the output n9 = NOR(n5,n8). A fault at net k forces net k in the faulty copy to `stuck_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch a search (sampled while idle or finished) |
| site | input | 4 | Net index of the fault |
| stuck_val | input | 1 | Stuck level of the fault |
| done | output | 1 | Search finished; verdict valid |
| found | output | 1 | A test was found |
| untestable | output | 1 | The fault has no test |
| test_vec | output | 5 | Test values for the inputs, bit i is xi |
| test_care | output | 5 | Marks which bits of `test_vec` were assigned |

## Verification
Each search is launched on a known edge. The bench model replays the same decision walk and gives the number of evaluations N that the fault needs. The verdict is due exactly N edges later. The bench samples on every falling edge in between and expects `done` low until edge N and high from edge N on. Only then does it compare the verdict, the vector and the care mask. A `start` pulse injected mid-search must leave both the due edge and the result unchanged. Found vectors are also checked by filling every don't-care input both ways.

// File: rtl/podem_pkg.sv
package podem_pkg;
  localparam int NUM_PI  = 5;
  localparam int NUM_NET = 10;
  localparam int OUT_NET = NUM_NET - 1;
  localparam int SITE_W  = 4;
  localparam int LVL_W   = $clog2(NUM_PI + 1);

  // three-valued code: bit 1 set means unknown
  typedef logic [1:0] tri_t;
  localparam tri_t V0 = 2'b00;
  localparam tri_t V1 = 2'b01;
  localparam tri_t VX = 2'b10;

  typedef tri_t [NUM_PI-1:0]  piv_t;
  typedef tri_t [NUM_NET-1:0] netv_t;

  typedef enum logic [1:0] {S_IDLE, S_SEARCH, S_DONE} eng_state_t;

  function automatic tri_t t_and(input tri_t a, input tri_t b);
    if (a == V0 || b == V0)      return V0;
    else if (a == V1 && b == V1) return V1;
    else                         return VX;
  endfunction

  function automatic tri_t t_or(input tri_t a, input tri_t b);
    if (a == V1 || b == V1)      return V1;
    else if (a == V0 && b == V0) return V0;
    else                         return VX;
  endfunction

  function automatic tri_t t_not(input tri_t a);
    if (a == V0)      return V1;
    else if (a == V1) return V0;
    else              return VX;
  endfunction
endpackage

// File: rtl/podem_eval.sv
module podem_eval
  import podem_pkg::*;
(
  input  piv_t              pi_vals,
  input  logic [SITE_W-1:0] site,
  input  logic              sv,
  output logic              success,
  output logic              reject
);
  function automatic tri_t pin(input int k, input tri_t v, input logic en,
                               input logic [SITE_W-1:0] s, input logic b);
    return (en && s == SITE_W'(k)) ? {1'b0, b} : v;
  endfunction

  function automatic netv_t sim(input piv_t p, input logic en,
                                input logic [SITE_W-1:0] s, input logic b);
    netv_t n;
    for (int k = 0; k < NUM_PI; k++) n[k] = pin(k, p[k], en, s, b);
    n[5] = pin(5, t_not(t_and(n[0], n[1])), en, s, b);
    n[6] = pin(6, t_or(n[2], n[3]), en, s, b);
    n[7] = pin(7, t_and(n[6], n[2]), en, s, b);
    n[8] = pin(8, t_and(n[7], n[4]), en, s, b);
    n[9] = pin(9, t_not(t_or(n[5], n[8])), en, s, b);
    return n;
  endfunction

  netv_t              gd, fl;
  logic [NUM_NET-1:0] isx, isd, hit, ok;
  logic               exc_bad;

  always_comb begin
    gd = sim(pi_vals, 1'b0, site, sv);
    fl = sim(pi_vals, 1'b1, site, sv);
    exc_bad = 1'b0;
    for (int n = 0; n < NUM_NET; n++) begin
      isx[n] = gd[n][1] | fl[n][1];
      isd[n] = !isx[n] && (gd[n] != fl[n]);
      hit[n] = (site == SITE_W'(n));
      if (hit[n] && gd[n] == {1'b0, sv}) exc_bad = 1'b1;
    end
    // open route to the output through unknown nets, per fanout of the network
    ok[9] = 1'b1;
    ok[8] = isx[9] & ok[9];
    ok[5] = isx[9] & ok[9];
    ok[7] = isx[8] & ok[8];
    ok[4] = isx[8] & ok[8];
    ok[6] = isx[7] & ok[7];
    ok[3] = isx[6] & ok[6];
    ok[2] = (isx[6] & ok[6]) | (isx[7] & ok[7]);
    ok[1] = isx[5] & ok[5];
    ok[0] = isx[5] & ok[5];
    success = isd[OUT_NET];
    reject  = exc_bad | ~(|(ok & (isd | (hit & isx))));
  end
endmodule

// File: rtl/podem_stack.sv
module podem_stack
  import podem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              back,
  output logic              empty,
  output piv_t              pi_vals,
  output logic [NUM_PI-1:0] val,
  output logic [NUM_PI-1:0] care
);
  logic [NUM_PI-1:0] val_q, val_d, flg_q, flg_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [LVL_W-1:0]  bt_idx;

  always_comb begin
    empty  = 1'b1;
    bt_idx = '0;
    for (int j = 0; j < NUM_PI; j++) begin
      if (lvl_q > LVL_W'(j) && !flg_q[j]) begin
        empty  = 1'b0;
        bt_idx = LVL_W'(j);
      end
    end
  end

  always_comb begin
    val_d = val_q;
    flg_d = flg_q;
    lvl_d = lvl_q;
    if (clr) begin
      val_d = '0;
      flg_d = '0;
      lvl_d = '0;
    end else if (push && lvl_q < LVL_W'(NUM_PI)) begin
      val_d[lvl_q] = 1'b0;
      flg_d[lvl_q] = 1'b0;
      lvl_d        = lvl_q + 1'b1;
    end else if (back && !empty) begin
      val_d[bt_idx] = 1'b1;
      flg_d[bt_idx] = 1'b1;
      lvl_d         = bt_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      flg_q <= '0;
      lvl_q <= '0;
    end else if (clr || push || back) begin
      val_q <= val_d;
      flg_q <= flg_d;
      lvl_q <= lvl_d;
    end
  end

  generate
    for (genvar i = 0; i < NUM_PI; i++) begin : g_pi
      assign care[i]    = (lvl_q > LVL_W'(i));
      assign pi_vals[i] = care[i] ? {1'b0, val_q[i]} : VX;
    end
  endgenerate
  assign val = val_q;
endmodule

// File: rtl/podem_engine.sv
module podem_engine
  import podem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SITE_W-1:0] site,
  input  logic              stuck_val,
  output logic              done,
  output logic              found,
  output logic              untestable,
  output logic [NUM_PI-1:0] test_vec,
  output logic [NUM_PI-1:0] test_care
);
  logic              rst_meta, rst_int;
  eng_state_t        st_q, st_d;
  logic [SITE_W-1:0] site_q;
  logic              sv_q, found_q, found_d, untest_q, untest_d;
  logic              launch, clr, push, back;
  logic              success, reject, empty;
  piv_t              pi_vals;
  logic [NUM_PI-1:0] val, care;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_int, rst_meta} <= 2'b00;
    else        {rst_int, rst_meta} <= {rst_meta, 1'b1};
  end

  assign launch = start && (st_q != S_SEARCH);

  podem_stack i_stack (
    .clk(clk), .rst_n(rst_int), .clr(clr), .push(push), .back(back),
    .empty(empty), .pi_vals(pi_vals), .val(val), .care(care)
  );

  podem_eval i_eval (
    .pi_vals(pi_vals), .site(site_q), .sv(sv_q),
    .success(success), .reject(reject)
  );

  always_comb begin
    st_d     = st_q;
    found_d  = found_q;
    untest_d = untest_q;
    clr      = 1'b0;
    push     = 1'b0;
    back     = 1'b0;
    if (launch) begin
      st_d     = S_SEARCH;
      found_d  = 1'b0;
      untest_d = 1'b0;
      clr      = 1'b1;
    end else if (st_q == S_SEARCH) begin
      if (success) begin
        st_d    = S_DONE;
        found_d = 1'b1;
      end else if (reject) begin
        if (empty) begin
          st_d     = S_DONE;
          untest_d = 1'b1;
        end else begin
          back = 1'b1;
        end
      end else begin
        push = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      st_q     <= S_IDLE;
      site_q   <= '0;
      sv_q     <= 1'b0;
      found_q  <= 1'b0;
      untest_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      found_q  <= found_d;
      untest_q <= untest_d;
      if (launch) begin
        site_q <= site;
        sv_q   <= stuck_val;
      end
    end
  end

  assign done       = (st_q == S_DONE);
  assign found      = found_q;
  assign untestable = untest_q;
  assign test_care  = found_q ? care : '0;
  assign test_vec   = found_q ? (val & care) : '0;
endmodule

// File: rtl/podem_engine_chk.sv
module podem_engine_chk
  import podem_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [SITE_W-1:0] site,
  input logic              stuck_val,
  input logic              done,
  input logic              found,
  input logic              untestable,
  input logic [NUM_PI-1:0] test_vec,
  input logic [NUM_PI-1:0] test_care
);
  a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (found ^ untestable));

  a_r1_quiet_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!found && !untestable && test_care == '0));

  a_r3_care_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (test_care & (test_care + 1'b1)) == '0);

  a_r3_vec_in_care: assert property (@(posedge clk) disable iff (!rst_n)
    (test_vec & ~test_care) == '0);

  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(found) && $stable(test_vec) && $stable(test_care)));

  a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done);

  a_r8_untest_empty: assert property (@(posedge clk) disable iff (!rst_n)
    untestable |-> (test_care == '0 && test_vec == '0));
endmodule

bind podem_engine podem_engine_chk i_chk (.*);

// File: tb/test_podem_engine.sv
module test_podem_engine;
  logic       clk, rst_n, start, stuck_val;
  logic [3:0] site;
  logic       done, found, untestable;
  logic [4:0] test_vec, test_care;
  int checks = 0;
  int fails  = 0;

  podem_engine i_podem_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .site(site), .stuck_val(stuck_val),
    .done(done), .found(found), .untestable(untestable),
    .test_vec(test_vec), .test_care(test_care)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---- behavioural reference: values 0, 1, 2 (= unknown) ----
  function automatic int b_and(int a, int b);
    if (a == 0 || b == 0) return 0;
    if (a == 1 && b == 1) return 1;
    return 2;
  endfunction
  function automatic int b_or(int a, int b);
    if (a == 1 || b == 1) return 1;
    if (a == 0 && b == 0) return 0;
    return 2;
  endfunction
  function automatic int b_not(int a);
    return (a == 2) ? 2 : 1 - a;
  endfunction

  function automatic void net_sim(input int pi[5], input bit flt, input int fs,
                                  input int fv, output int n[10]);
    for (int k = 0; k < 10; k++) begin
      case (k)
        5: n[k] = b_not(b_and(n[0], n[1]));
        6: n[k] = b_or(n[2], n[3]);
        7: n[k] = b_and(n[6], n[2]);
        8: n[k] = b_and(n[7], n[4]);
        9: n[k] = b_not(b_or(n[5], n[8]));
        default: n[k] = pi[k];
      endcase
      if (flt && fs == k) n[k] = fv;
    end
  endfunction

  // fanout edges of the network (from, to)
  int ef[10] = '{0, 1, 2, 3, 6, 2, 7, 4, 5, 8};
  int et[10] = '{5, 5, 6, 6, 7, 7, 8, 8, 9, 9};

  task automatic model(input int fs, input int fv, output int ncyc, output int fnd,
                       output int vec, output int care);
    int v[5];
    int f[5];
    int lvl = 0;
    ncyc = 0;
    fnd = 0;
    vec = 0;
    care = 0;
    v = '{0, 0, 0, 0, 0};
    f = '{0, 0, 0, 0, 0};
    forever begin
      int pi[5];
      int g[10];
      int b[10];
      bit x[10];
      bit d[10];
      bit reach[10];
      bit rej;
      bit cand;
      ncyc++;
      for (int i = 0; i < 5; i++) pi[i] = (i < lvl) ? v[i] : 2;
      net_sim(pi, 1'b0, fs, fv, g);
      net_sim(pi, 1'b1, fs, fv, b);
      for (int k = 0; k < 10; k++) begin
        x[k] = (g[k] == 2) || (b[k] == 2);
        d[k] = !x[k] && (g[k] != b[k]);
        reach[k] = (k == 9);
      end
      if (d[9]) begin
        fnd = 1;
        for (int i = 0; i < lvl; i++) begin
          care |= (1 << i);
          vec  |= (v[i] << i);
        end
        return;
      end
      for (int r = 0; r < 10; r++)
        for (int e = 0; e < 10; e++)
          if (x[et[e]] && reach[et[e]]) reach[ef[e]] = 1'b1;
      cand = 1'b0;
      for (int k = 0; k < 10; k++)
        if (reach[k] && (d[k] || (k == fs && x[k]))) cand = 1'b1;
      rej = !cand || (fs < 10 && g[fs] == fv);
      if (rej) begin
        int j = lvl - 1;
        while (j >= 0 && f[j] == 1) j--;
        if (j < 0) return;
        v[j] = 1;
        f[j] = 1;
        lvl = j + 1;
      end else begin
        v[lvl] = 0;
        f[lvl] = 0;
        lvl++;
      end
    end
  endtask

  // R7: every filling of the don't-care inputs must expose the fault
  task automatic verify_test(input int fs, input int fv);
    bit all_ok = 1'b1;
    for (int fill = 0; fill < 32; fill++) begin
      int pi[5];
      int g[10];
      int b[10];
      if ((fill & test_care) != test_vec) continue;
      for (int i = 0; i < 5; i++) pi[i] = (fill >> i) & 1;
      net_sim(pi, 1'b0, fs, fv, g);
      net_sim(pi, 1'b1, fs, fv, b);
      if (g[9] == b[9]) all_ok = 1'b0;
    end
    chk(all_ok, "R7", "vector exposes fault", int'(test_vec), int'(test_vec));
  endtask

  // runs one search; glitch_at > 0 pulses start at that evaluation (R10)
  task automatic run_case(input int fs, input int fv, input int glitch_at,
                          output int ncyc, output int fnd, output int vec, output int care);
    model(fs, fv, ncyc, fnd, vec, care);
    @(negedge clk);
    site = 4'(fs);
    stuck_val = fv[0];
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    site = 4'(15 - fs);
    stuck_val = ~fv[0];
    for (int k = 1; k <= ncyc; k++) begin
      if (k == glitch_at) start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      // R2: done rises exactly at the deciding evaluation
      chk(done == (k == ncyc), "R2", $sformatf("done at evaluation %0d", k),
          int'(done), int'(k == ncyc));
    end
    chk(found == fnd[0], "R7", "found", int'(found), fnd);
    chk(untestable == !fnd[0], "R8", "untestable", int'(untestable), int'(!fnd[0]));
    chk(int'(test_care) == care, "R3", "care mask", int'(test_care), care);
    chk(int'(test_vec) == vec, "R3", "test vector", int'(test_vec), vec);
    if (fnd == 1) verify_test(fs, fv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    int nc, fd, vc, cr;
    rst_n = 1'b0;
    start = 1'b0;
    site = '0;
    stuck_val = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!done && !found && !untestable && test_vec == 0 && test_care == 0,
        "R1", "reset outputs", int'({done, found, untestable}), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!done && test_care == 0, "R1", "idle after release", int'(done), 0);

    // R4 R6 R11: output stuck-at-0, hand-derived walk of 6 evaluations, x0=1 x1=1 x2=0
    run_case(9, 0, 0, nc, fd, vc, cr);
    chk(nc == 6 && fd == 1, "R6", "model walk length", nc, 6);
    chk(test_vec == 5'b00011 && test_care == 5'b00111, "R4", "hand vector",
        int'({test_care, test_vec}), int'({5'b00111, 5'b00011}));

    // R8: redundant fault on net 6 stuck-at-1
    run_case(6, 1, 0, nc, fd, vc, cr);
    chk(untestable && !found, "R8", "redundant fault", int'(untestable), 1);

    // R9: out-of-range site
    run_case(12, 0, 0, nc, fd, vc, cr);
    chk(nc == 1 && untestable, "R9", "invalid site", nc, 1);

    // R10: start mid-search has no effect on timing or result
    run_case(6, 0, 2, nc, fd, vc, cr);
    chk(found, "R10", "found despite start pulse", int'(found), 1);
    repeat (3) @(negedge clk);
    chk(done && found && int'(test_vec) == vc, "R10", "result held",
        int'(test_vec), vc);

    // R5 R3: sweep every net and stuck level against the model
    for (int s = 0; s < 10; s++)
      for (int b = 0; b < 2; b++)
        run_case(s, b, 0, nc, fd, vc, cr);
    run_case(15, 1, 0, nc, fd, vc, cr);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule